// File: doc/BRIEF.md
# Push-Button Modulation Index Ramp

This block holds the unsigned offset that is added to each of the three sawtooth references of a PWM voltage regulator, and so sets the modulation index between 0 and 1.5. An operator raises or lowers the offset with two push buttons. The block samples the button levels through a synchronizer. It moves the offset by one fixed step on a slow periodic tick, which at the default settings is once per 0.1 s from a 50 MHz clock. Holding the up button from reset ramps the motor voltage slowly from zero, which gives a manual soft start.

The span from 0 to the full-scale offset (69444) is divided into 256 steps of 271. A level counter from 0 to 256 tracks the position. The top level maps exactly to full scale, and every lower level n maps to n times the step. An 8-bit step count for a display is also output. Both results are registered and move only on a tick.

Top module: `modramp_ctl`

## Requirements
- R1: While reset is high, the next clock edge sets offset to 0 and step count to 0. The reset is synchronous and active high.
- R2: Offset and step count change only on a tick. After reset, a tick falls on every TICK_DIV-th clock edge, with a default of 5,000,000 edges, which is 0.1 s at 50 MHz.
- R3: On a tick with only the up button seen as held, and the level below 255, the offset rises by STEP (271) and the step count rises by 1.
- R4: On a tick with only the down button seen as held, and the level between 1 and 255, the offset falls by 271 and the step count falls by 1.
- R5: Level 256 maps to an offset of OFF_MAX (69444). Up at level 256 leaves the outputs unchanged. The step count shows 255 at levels 255 and 256. Down from level 256 gives offset 255*271 = 69105.
- R6: Down at level 0 leaves offset 0 and step count 0. The offset never wraps.
- R7: A tick with both buttons held, or with neither held, leaves both outputs unchanged.
- R8: Each button passes through two synchronizer flops. The update at a tick edge uses the level that was sampled two clock edges earlier. A press that is sampled only on the edge just before the tick edge is not seen by that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| btn_up | input | 1 | Raise button level, asynchronous |
| btn_dn | input | 1 | Lower button level, asynchronous |
| offset | output | OFF_W (17) | Offset added to every sawtooth |
| step_cnt | output | CNT_W (8) | Step count for display |

## Verification
A button level reaches the update logic two edges after it is sampled. The offset and the step count then change on the tick edge itself, TICK_DIV edges after the previous tick. The bench shortens TICK_DIV to 8. Its reference model counts edges since reset and keeps a two-deep history of the button levels, so it knows which edge changes the outputs. It compares both outputs on every falling edge, half a period after the rising edge, and its synchronizer tests place single-edge presses on the edge two before a tick and on the edge one before a tick.

// File: rtl/modramp_pkg.sv
package modramp_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_UP   = 2'd1,
    CMD_DOWN = 2'd2
  } ramp_cmd_e;

  // Both or neither pressed: hold.
  function automatic ramp_cmd_e decode_cmd(input logic up, input logic dn);
    if (up && !dn)      return CMD_UP;
    else if (dn && !up) return CMD_DOWN;
    else                return CMD_HOLD;
  endfunction
endpackage

// File: rtl/mi_sync.sv
module mi_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mi_tick.sv
module mi_tick #(
  parameter int DIV = 5000000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/mi_level.sv
module mi_level
  import modramp_pkg::*;
#(
  parameter int OFF_W   = 17,
  parameter int CNT_W   = 8,
  parameter int STEPS   = 256,
  parameter int STEP    = 271,
  parameter int OFF_MAX = 69444
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  ramp_cmd_e        cmd,
  output logic [OFF_W-1:0] offset,
  output logic [CNT_W-1:0] step_cnt
);
  localparam int LVL_W = $clog2(STEPS + 1);
  localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(STEPS);
  localparam logic [LVL_W-1:0] LVL_PRE  = LVL_W'(STEPS - 1);
  localparam logic [OFF_W-1:0] OFF_STEP = OFF_W'(STEP);
  localparam logic [OFF_W-1:0] OFF_FULL = OFF_W'(OFF_MAX);
  localparam logic [OFF_W-1:0] OFF_GRID = OFF_W'((STEPS - 1) * STEP);
  localparam int CNT_CAP = (1 << CNT_W) - 1;

  logic [LVL_W-1:0] lvl, lvl_nxt;
  logic [OFF_W-1:0] off_nxt;

  always_comb begin
    lvl_nxt = lvl;
    off_nxt = offset;
    if (tick) begin
      unique case (cmd)
        CMD_UP: if (lvl != LVL_TOP) begin
          lvl_nxt = lvl + 1'b1;
          off_nxt = (lvl == LVL_PRE) ? OFF_FULL : offset + OFF_STEP;
        end
        CMD_DOWN: if (lvl != '0) begin
          lvl_nxt = lvl - 1'b1;
          off_nxt = (lvl == LVL_TOP) ? OFF_GRID : offset - OFF_STEP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl      <= '0;
      offset   <= '0;
      step_cnt <= '0;
    end else begin
      lvl      <= lvl_nxt;
      offset   <= off_nxt;
      step_cnt <= (int'(lvl_nxt) > CNT_CAP) ? CNT_W'(CNT_CAP) : CNT_W'(lvl_nxt);
    end
  end
endmodule

// File: rtl/modramp_ctl.sv
module modramp_ctl
  import modramp_pkg::*;
#(
  parameter int TICK_DIV = 5000000,
  parameter int OFF_W    = 17,
  parameter int CNT_W    = 8,
  parameter int STEPS    = 256,
  parameter int STEP     = 271,
  parameter int OFF_MAX  = 69444,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_up,
  input  logic             btn_dn,
  output logic [OFF_W-1:0] offset,
  output logic [CNT_W-1:0] step_cnt
);
  logic [1:0] btn_s;
  logic       tick;
  ramp_cmd_e  cmd;

  mi_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d({btn_dn, btn_up}), .q(btn_s)
  );

  mi_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  assign cmd = decode_cmd(btn_s[0], btn_s[1]);

  mi_level #(
    .OFF_W(OFF_W), .CNT_W(CNT_W), .STEPS(STEPS),
    .STEP(STEP), .OFF_MAX(OFF_MAX)
  ) u_level (
    .clk(clk), .rst(rst), .tick(tick), .cmd(cmd),
    .offset(offset), .step_cnt(step_cnt)
  );
endmodule

// File: rtl/mi_ramp_chk.sv
module mi_ramp_chk #(
  parameter int OFF_W   = 17,
  parameter int CNT_W   = 8,
  parameter int STEP    = 271,
  parameter int OFF_MAX = 69444
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [1:0]       btn_s,
  input logic [OFF_W-1:0] offset,
  input logic [CNT_W-1:0] step_cnt
);
  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (offset == '0 && step_cnt == '0)); // R1

  AST_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(offset) && $stable(step_cnt))); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && btn_s == 2'b01 && step_cnt < CNT_W'(254)) |=>
      (int'(offset) == int'($past(offset)) + STEP)); // R3

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && btn_s == 2'b10 && step_cnt != '0 && int'(offset) != OFF_MAX) |=>
      (int'(offset) == int'($past(offset)) - STEP)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(offset) <= OFF_MAX); // R5

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tick && btn_s == 2'b11) |=> $stable(offset)); // R7
endmodule

bind modramp_ctl mi_ramp_chk #(
  .OFF_W(OFF_W), .CNT_W(CNT_W), .STEP(STEP), .OFF_MAX(OFF_MAX)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .btn_s(btn_s),
  .offset(offset), .step_cnt(step_cnt)
);

// File: tb/test_modramp_ctl.sv
`timescale 1ns/1ps
module test_modramp_ctl;
  localparam int TDIV = 8;
  localparam int FULL = 69444;
  localparam int STP  = 271;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up  = 1'b0;
  logic dn  = 1'b0;
  logic [16:0] offset;
  logic [7:0]  step_cnt;

  always #2 clk = ~clk;

  modramp_ctl #(.TICK_DIV(TDIV)) i_modramp_ctl (
    .clk(clk), .rst(rst), .btn_up(up), .btn_dn(dn),
    .offset(offset), .step_cnt(step_cnt)
  );

  int errors = 0;
  int checks = 0;
  int k = 0;
  int lvl = 0;
  bit u1, u2, d1, d2;
  string phase = "R1";

  // Reference model: edge counter, two-deep button history, level.
  always @(posedge clk) begin
    if (rst) begin
      k = 0; lvl = 0; u1 = 0; u2 = 0; d1 = 0; d2 = 0;
    end else begin
      k++;
      if (k % TDIV == 0) begin
        if (u2 && !d2 && lvl < 256) lvl++;
        else if (d2 && !u2 && lvl > 0) lvl--;
      end
      u2 = u1; u1 = up;
      d2 = d1; d1 = dn;
    end
  end

  function automatic int exp_off(int l);
    return (l == 256) ? FULL : l * STP;
  endfunction
  function automatic int exp_cnt(int l);
    return (l > 255) ? 255 : l;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at edge %0d", tag, act, exp, k);
    end
  endtask

  // Per-cycle comparison, half a period after each rising edge.
  always @(negedge clk) begin
    chk({phase, " offset"}, int'(offset), exp_off(lvl));
    chk({phase, " step_cnt"}, int'(step_cnt), exp_cnt(lvl));
  end

  task automatic ticks(int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  // Place a one-edge press so it is sampled exactly at edge e.
  task automatic pulse_at(int e, bit is_up);
    while (k != e - 1) @(negedge clk);
    if (is_up) up = 1'b1; else dn = 1'b1;
    @(negedge clk);
    up = 1'b0; dn = 1'b0;
  endtask

  int base;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset offset", int'(offset), 0);
    chk("R1 reset step_cnt", int'(step_cnt), 0);
    rst = 1'b0;

    phase = "R2 idle";
    ticks(3);

    phase = "R3";
    up = 1'b1;
    ticks(20);
    up = 1'b0;
    ticks(2);

    phase = "R7 both";
    base = int'(offset);
    up = 1'b1; dn = 1'b1;
    ticks(5);
    up = 1'b0; dn = 1'b0;
    ticks(2);
    chk("R7 both held offset", int'(offset), base);

    phase = "R4";
    dn = 1'b1;
    ticks(6);
    dn = 1'b0;
    ticks(2);

    phase = "R5";
    up = 1'b1;
    ticks(270);
    chk("R5 top offset", int'(offset), FULL);
    chk("R5 top step_cnt", int'(step_cnt), 255);
    up = 1'b0;
    ticks(1);
    dn = 1'b1;
    ticks(1);
    ticks(1);
    dn = 1'b0;
    ticks(2);

    phase = "R6";
    dn = 1'b1;
    ticks(270);
    chk("R6 floor offset", int'(offset), 0);
    chk("R6 floor step_cnt", int'(step_cnt), 0);
    dn = 1'b0;
    ticks(2);

    phase = "R8";
    @(negedge clk);
    base = ((k / TDIV) + 2) * TDIV;
    pulse_at(base - 1, 1'b1);
    ticks(1);
    chk("R8 late press ignored", int'(offset), 0);
    base = ((k / TDIV) + 2) * TDIV;
    pulse_at(base - 2, 1'b1);
    ticks(1);
    chk("R8 early press taken", int'(offset), STP);

    phase = "R1 mid";
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset offset", int'(offset), 0);
    rst = 1'b0;
    ticks(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule